// File: doc/BRIEF.md
# Flash Page Read Buffer Controller

This controller sits between a simple single-request bus port and a slow flash array that can run only one access at a time. It holds four page buffers. Each buffer carries a 128-bit page, a tag made from address bits 23 down to 4, a valid bit and three status flags copied from the array. A read whose page is held in a valid buffer is answered in the same cycle. Any other access starts one array access. The controller then waits a programmable number of wait states, samples the array's result, and answers the bus one cycle later.

A read that completes cleanly fills the least recently used buffer, or a free one if any is free. When the array reports a transfer error, the bus receives the error and no buffer changes. Writes always go to the array. A clean write drops any buffer that holds the written page. A synchronous invalidate input empties all buffers at once. The requester holds its request stable until the response strobe. If it withdraws the request during an array access, the access still runs to the end, but the bus sees no response.

Top module: `flash_pagebuf`

## Requirements
- R1: After reset, no buffer is valid, `rsp_ready` and `fl_start` are low while no request is present, and the first read of any page is a miss.
- R2: A read whose `req_addr[23:4]` equals the tag of a valid buffer is a hit. `rsp_ready` is high in the same cycle and no array access is started. `rsp_rdata` is bits 32k+31..32k of the page, where k = `req_addr[3:2]`.
- R3: A miss raises `fl_start` in its request cycle, with `fl_addr` equal to `req_addr`. W is the larger of `cfg_rd_ws` and `cfg_pipe_ws`. The array result is sampled W+1 cycles later, and `rsp_ready` rises exactly W+2 cycles after the request cycle.
- R4: A read miss that completes without a transfer error stores the page, so a later read of any word in that page is a hit with matching data.
- R5: If `fl_xfr_err` is high when the result is sampled, `rsp_err` is high in the response cycle and no buffer is filled, so the next read of that page misses again.
- R6: The multi-bit and single-bit ECC flags from the array are returned with a miss response. They are stored with the page and returned again on every later hit of that page. The stored transfer-error flag reads 0.
- R7: Writes always start an array access and never fill a buffer. `rsp_err` reflects `fl_xfr_err`. A write that completes without error invalidates a buffer holding the same page.
- R8: Accesses are not pipelined. After `fl_start`, neither `fl_start` nor `rsp_ready` is asserted until the access completes. If `req_valid` drops during the access, the access completes and fills the buffer, but no `rsp_ready` pulse is given.
- R9: On a fill, an invalid buffer is chosen first (lowest index). Otherwise the least recently used buffer is chosen. Hits and fills both count as use.
- R10: `inv_all` clears every valid bit at the next clock edge. It wins over a fill that completes in the same cycle, although that access's response is still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd_ws | input | 4 | Read wait-state setting |
| cfg_pipe_ws | input | 4 | Address-pipelining wait setting; normally equal to `cfg_rd_ws` |
| inv_all | input | 1 | Invalidate all buffers |
| req_valid | input | 1 | Request present; held until `rsp_ready` |
| req_write | input | 1 | Request is a write |
| req_addr | input | 24 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | Response strobe; the request completes in this cycle |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Transfer error response |
| rsp_ecc_multi | output | 1 | Uncorrectable ECC indication |
| rsp_ecc_single | output | 1 | Corrected ECC indication |
| fl_start | output | 1 | One-cycle start of an array access |
| fl_write | output | 1 | Array access is a write |
| fl_addr | output | 24 | Array access address |
| fl_wdata | output | 32 | Array write data |
| fl_rdata | input | 128 | Page data from the array |
| fl_xfr_err | input | 1 | Array transfer error |
| fl_ecc_multi | input | 1 | Array multi-bit ECC flag |
| fl_ecc_single | input | 1 | Array single-bit ECC flag |

## Verification
Two functions can collide in one cycle: a read fill completing and `inv_all` being asserted. The bench provokes this by raising `inv_all` in the exact cycle the array result is sampled. It counts W+1 cycles from the request for each wait setting. The response is still judged correct, and a repeat read of the same page is required to miss with full latency. This shows that the invalidate won and no fill occurred.

// File: rtl/flash_pagebuf.sv
module flash_pagebuf #(
  parameter int AW  = 24,
  parameter int NB  = 4,
  parameter int WSW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [WSW-1:0] cfg_rd_ws,
  input  logic [WSW-1:0] cfg_pipe_ws,
  input  logic           inv_all,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [31:0]    req_wdata,
  output logic           rsp_ready,
  output logic [31:0]    rsp_rdata,
  output logic           rsp_err,
  output logic           rsp_ecc_multi,
  output logic           rsp_ecc_single,
  output logic           fl_start,
  output logic           fl_write,
  output logic [AW-1:0]  fl_addr,
  output logic [31:0]    fl_wdata,
  input  logic [127:0]   fl_rdata,
  input  logic           fl_xfr_err,
  input  logic           fl_ecc_multi,
  input  logic           fl_ecc_single
);
  localparam int TW = AW - 4;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} st_t;

  st_t            st;
  logic [WSW-1:0] cnt;
  logic [AW-1:0]  cur_addr;
  logic           cur_wr;
  logic           aband;
  logic [31:0]    res_data;
  logic           res_err, res_m, res_s;

  logic [NB-1:0]  vld;
  logic [TW-1:0]  tag [NB];
  logic [127:0]   dat [NB];
  logic [NB-1:0]  f_xe, f_me, f_se;
  logic [IW-1:0]  rank [NB];

  logic [NB-1:0]  hit_vec, kill_vec;
  logic [IW-1:0]  hit_idx, vic_idx, t_idx;
  logic           hit_any, idle_rd_hit, need_arr, finish, do_fill, wr_kill, touch;
  logic [WSW-1:0] ws_eff;
  logic           unused_bits;

  for (genvar g = 0; g < NB; g++) begin : g_cmp
    assign hit_vec[g]  = vld[g] && (tag[g] == req_addr[AW-1:4]);
    assign kill_vec[g] = vld[g] && (tag[g] == cur_addr[AW-1:4]);
  end

  assign hit_any     = |hit_vec;
  assign ws_eff      = (cfg_pipe_ws > cfg_rd_ws) ? cfg_pipe_ws : cfg_rd_ws;
  assign idle_rd_hit = (st == S_IDLE) && req_valid && !req_write && hit_any;
  assign need_arr    = req_valid && (req_write || !hit_any);
  assign finish      = (st == S_WAIT) && (cnt == '0);
  assign do_fill     = finish && !cur_wr && !fl_xfr_err && !inv_all;
  assign wr_kill     = finish && cur_wr && !fl_xfr_err;
  assign touch       = idle_rd_hit || do_fill;
  assign t_idx       = idle_rd_hit ? hit_idx : vic_idx;
  assign unused_bits = ^{req_addr[1:0], cur_addr[1:0]};

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NB; i++)
      if (hit_vec[i]) hit_idx = IW'(i);
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    vic_idx = '0;
    for (int i = 0; i < NB; i++)
      if (!found && !vld[i]) begin
        vic_idx = IW'(i);
        found   = 1'b1;
      end
    for (int i = 0; i < NB; i++)
      if (!found && rank[i] == IW'(NB - 1)) vic_idx = IW'(i);
  end

  assign fl_start = (st == S_IDLE) && need_arr;
  assign fl_write = req_write;
  assign fl_addr  = req_addr;
  assign fl_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      cur_addr <= '0;
      cur_wr   <= 1'b0;
      aband    <= 1'b0;
      res_data <= '0;
      res_err  <= 1'b0;
      res_m    <= 1'b0;
      res_s    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (need_arr) begin
          st       <= S_WAIT;
          cnt      <= ws_eff;
          cur_addr <= req_addr;
          cur_wr   <= req_write;
          aband    <= 1'b0;
        end
        S_WAIT: begin
          if (!req_valid) aband <= 1'b1;
          if (cnt == '0) begin
            st       <= S_DONE;
            res_data <= fl_rdata[{cur_addr[3:2], 5'b0} +: 32];
            res_err  <= fl_xfr_err;
            res_m    <= fl_ecc_multi;
            res_s    <= fl_ecc_single;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else if (inv_all) vld <= '0;
    else if (do_fill) vld[vic_idx] <= 1'b1;
    else if (wr_kill) vld <= vld & ~kill_vec;
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag[vic_idx]  <= cur_addr[AW-1:4];
      dat[vic_idx]  <= fl_rdata;
      f_xe[vic_idx] <= fl_xfr_err;
      f_me[vic_idx] <= fl_ecc_multi;
      f_se[vic_idx] <= fl_ecc_single;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) rank[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < NB; i++)
        if (IW'(i) == t_idx) rank[i] <= '0;
        else if (rank[i] < rank[t_idx]) rank[i] <= rank[i] + 1'b1;
    end
  end

  assign rsp_ready      = idle_rd_hit || (st == S_DONE && !aband);
  assign rsp_rdata      = idle_rd_hit ? dat[hit_idx][{req_addr[3:2], 5'b0} +: 32] :
                          (st == S_DONE) ? res_data : '0;
  assign rsp_err        = idle_rd_hit ? f_xe[hit_idx] : (st == S_DONE) && res_err;
  assign rsp_ecc_multi  = idle_rd_hit ? f_me[hit_idx] : (st == S_DONE) && res_m;
  assign rsp_ecc_single = idle_rd_hit ? f_se[hit_idx] : (st == S_DONE) && res_s;

  logic [NB-1:0] rank_seen;
  always_comb begin
    rank_seen = '0;
    for (int i = 0; i < NB; i++) rank_seen[rank[i]] = 1'b1;
  end

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |=> (!rsp_ready && !fl_start)); // R8
  AST_ERR_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && fl_xfr_err) |=> ((vld & ~$past(vld)) == '0)); // R5
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld == '0)); // R10
  AST_LRU_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    (rank_seen == '1)); // R9
endmodule

// File: tb/flash_pagebuf_tb_top.sv
module flash_pagebuf_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cfg_rd_ws = 4'd1, cfg_pipe_ws = 4'd1;
  logic inv_all = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ready, rsp_err, rsp_ecc_multi, rsp_ecc_single;
  logic [31:0] rsp_rdata;
  logic fl_start, fl_write;
  logic [23:0] fl_addr;
  logic [31:0] fl_wdata;
  logic [127:0] fl_rdata;
  logic fl_xfr_err, fl_ecc_multi, fl_ecc_single;

  always #(CLK_P/2) clk = ~clk;

  flash_pagebuf dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_rd_ws(cfg_rd_ws), .cfg_pipe_ws(cfg_pipe_ws),
    .inv_all(inv_all), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_ecc_multi(rsp_ecc_multi),
    .rsp_ecc_single(rsp_ecc_single), .fl_start(fl_start), .fl_write(fl_write),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .fl_xfr_err(fl_xfr_err), .fl_ecc_multi(fl_ecc_multi), .fl_ecc_single(fl_ecc_single));

  localparam logic [19:0] ERR_PG = 20'hEEE00;
  localparam logic [19:0] M_PG   = 20'hAAA00;
  localparam logic [19:0] S_PG   = 20'hBBB00;

  function automatic logic [31:0] wexp(input logic [21:0] widx);
    return ({10'd0, widx} * 32'h9E3779B1) ^ 32'h0F0F1234;
  endfunction

  logic [23:0] m_addr = '0;
  int n_starts = 0;
  always_ff @(posedge clk) if (fl_start) begin
    m_addr   <= fl_addr;
    n_starts <= n_starts + 1;
  end
  assign fl_rdata = {wexp({m_addr[23:4], 2'd3}), wexp({m_addr[23:4], 2'd2}),
                     wexp({m_addr[23:4], 2'd1}), wexp({m_addr[23:4], 2'd0})};
  assign fl_xfr_err    = (m_addr[23:4] == ERR_PG);
  assign fl_ecc_multi  = (m_addr[23:4] == M_PG);
  assign fl_ecc_single = (m_addr[23:4] == S_PG);

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [23:0] a, input int inv_at,
                        output int lat, output logic [31:0] d, output logic e, m, s);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = ~{8'd0, a};
    lat = 0; inv_all = (inv_at == 0);
    d = '0; e = 1'b0; m = 1'b0; s = 1'b0;
    forever begin
      #1;
      if (rsp_ready) begin
        d = rsp_rdata; e = rsp_err; m = rsp_ecc_multi; s = rsp_ecc_single;
        break;
      end
      @(negedge clk);
      lat++;
      inv_all = (lat == inv_at);
      if (lat > 40) break;
    end
    inv_all = 1'b0;
  endtask

  task automatic go_idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic inv_pulse();
    @(negedge clk); req_valid = 1'b0; inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
  endtask

  task automatic rd_miss(input logic [23:0] a, input int w, input string rq);
    int lat; logic [31:0] d; logic e, m, s;
    access(1'b0, a, -1, lat, d, e, m, s);
    chk(lat == w + 2, {rq, " miss latency"}, lat, w + 2);
    chk(d == wexp(a[23:2]), {rq, " miss data"}, d, wexp(a[23:2]));
  endtask

  task automatic rd_hit(input logic [23:0] a, input string rq);
    int lat; logic [31:0] d; logic e, m, s;
    access(1'b0, a, -1, lat, d, e, m, s);
    chk(lat == 0, {rq, " hit latency"}, lat, 0);
    chk(d == wexp(a[23:2]), {rq, " hit data"}, d, wexp(a[23:2]));
  endtask

  initial begin
    int lat, w, st0; logic [31:0] d; logic e, m, s;
    logic [23:0] base;
    repeat (3) @(negedge clk);
    #1;
    chk(rsp_ready == 1'b0, "R1 ready low in reset", rsp_ready, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(rsp_ready == 1'b0, "R1 ready low idle", rsp_ready, 0);
    chk(fl_start == 1'b0, "R1 no start idle", fl_start, 0);
    rd_miss(24'h000040, 1, "R1");

    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 4; p++) begin
        inv_pulse();
        cfg_rd_ws = 4'(r); cfg_pipe_ws = 4'(p);
        w = (p > r) ? p : r;
        base = 24'h010000 + 24'((r * 4 + p) * 16);
        rd_miss(base + 24'(4 * ((r + p) % 4)), w, "R3 R4");
        for (int k = 0; k < 4; k++) rd_hit(base + 24'(4 * k), "R2");
      end

    cfg_rd_ws = 4'd2; cfg_pipe_ws = 4'd2; w = 2;
    inv_pulse();
    rd_miss(24'h000100, w, "R9 A"); rd_miss(24'h000200, w, "R9 B");
    rd_miss(24'h000300, w, "R9 C"); rd_miss(24'h000400, w, "R9 D");
    rd_hit(24'h000104, "R9 A"); rd_hit(24'h000208, "R9 B");
    rd_hit(24'h00030C, "R9 C"); rd_hit(24'h000400, "R9 D");
    rd_miss(24'h000500, w, "R9 E evicts A");
    rd_hit(24'h000404, "R9 D");
    rd_miss(24'h000100, w, "R9 A evicts B");
    rd_hit(24'h000500, "R9 E");
    rd_miss(24'h000200, w, "R9 B evicts C");
    rd_miss(24'h000300, w, "R9 C evicts D");

    access(1'b0, {ERR_PG, 4'h4}, -1, lat, d, e, m, s);
    chk(lat == w + 2, "R5 err latency", lat, w + 2);
    chk(e == 1'b1, "R5 err flagged", e, 1);
    access(1'b0, {ERR_PG, 4'h4}, -1, lat, d, e, m, s);
    chk(lat == w + 2, "R5 no fill after err", lat, w + 2);
    chk(e == 1'b1, "R5 err again", e, 1);

    access(1'b0, {M_PG, 4'h8}, -1, lat, d, e, m, s);
    chk(m == 1'b1 && s == 1'b0, "R6 multi on miss", {m, s}, 2'b10);
    access(1'b0, {M_PG, 4'h0}, -1, lat, d, e, m, s);
    chk(lat == 0 && m == 1'b1 && e == 1'b0, "R6 multi on hit", {lat[3:0], e, m}, 6'b000001);
    access(1'b0, {S_PG, 4'hC}, -1, lat, d, e, m, s);
    chk(s == 1'b1 && m == 1'b0, "R6 single on miss", {m, s}, 2'b01);
    access(1'b0, {S_PG, 4'h4}, -1, lat, d, e, m, s);
    chk(lat == 0 && s == 1'b1 && m == 1'b0, "R6 single on hit", {lat[3:0], m, s}, 6'b000001);

    rd_miss(24'h000600, w, "R7 prep");
    rd_miss(24'h000700, w, "R7 prep2");
    st0 = n_starts;
    access(1'b1, 24'h000604, -1, lat, d, e, m, s);
    chk(lat == w + 2 && e == 1'b0, "R7 write latency", lat, w + 2);
    chk(n_starts == st0 + 1, "R7 write starts access", n_starts - st0, 1);
    rd_miss(24'h000600, w, "R7 written page invalidated");
    rd_hit(24'h000700, "R7 other page kept");
    access(1'b1, {ERR_PG, 4'h0}, -1, lat, d, e, m, s);
    chk(e == 1'b1, "R7 write error", e, 1);
    access(1'b1, 24'h000800, -1, lat, d, e, m, s);
    chk(lat == w + 2, "R7 write miss latency", lat, w + 2);
    rd_miss(24'h000800, w, "R7 write no fill");

    st0 = n_starts;
    rd_hit(24'h000700, "R8 hit no start");
    chk(n_starts == st0, "R8 hit no start count", n_starts - st0, 0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h000900;
    #1; chk(fl_start == 1'b1, "R8 miss starts", fl_start, 1);
    @(negedge clk); req_valid = 1'b0;
    for (int c = 0; c < w + 4; c++) begin
      #1;
      chk(rsp_ready == 1'b0 && fl_start == 1'b0, "R8 abandoned silent", {rsp_ready, fl_start}, 0);
      @(negedge clk);
    end
    chk(n_starts == st0 + 1, "R8 single start", n_starts - st0, 1);
    rd_hit(24'h000908, "R8 abandoned access filled");

    for (int ww = 0; ww < 4; ww++) begin
      cfg_rd_ws = 4'(ww); cfg_pipe_ws = 4'(ww);
      base = 24'h020000 + 24'(ww * 16);
      access(1'b0, base + 24'h4, ww + 1, lat, d, e, m, s);
      chk(lat == ww + 2 && d == wexp(base[23:2] + 22'd1) && e == 1'b0,
          "R10 response kept on inv+fill", d, wexp(base[23:2] + 22'd1));
      rd_miss(base, ww, "R10 invalidate beats fill");
    end
    cfg_rd_ws = 4'd1; cfg_pipe_ws = 4'd1;
    rd_miss(24'h000A00, 1, "R10 prep");
    rd_hit(24'h000A00, "R10 prep");
    inv_pulse();
    rd_miss(24'h000A00, 1, "R10 idle invalidate");
    go_idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule